// File: doc/BRIEF.md
# Palette Lookup and Layer Mixer

This block is the last per-pixel stage of a video pipeline. Each cycle it can take one pixel made of a polygon-layer colour and a text-layer colour code, and it produces one 24-bit RGB value. The text code (a 4-bit colour bank and a 4-bit pixel nibble) is combined with a programmable palette base. The result indexes a palette that is kept as three separate 8-bit planes for red, green and blue. An opaque text pixel wins over a polygon pixel. A polygon pixel wins over the programmable background colour. Each layer can be switched off.

A 32-bit CPU write port with byte enables loads the palette planes and the mixer control registers. Each palette word carries two entries. Each control word carries two 16-bit registers, with the even-numbered register in the upper half. The palette depth is a parameter: the full size is 15 index bits, and smaller depths are used in simulation. A palette read takes one registered cycle. The valid flag and a sideband bus travel through a matching register, so the output stays aligned with them.

Top module: `pal_mixer`

## Requirements
- R1: A palette write with `pal_we_i` uses address bits [IDX_W:IDX_W-1] as the plane (0 red, 1 green, 2 blue) and bits [IDX_W-2:0] as word w. Data bits 23:16 become entry 2w and bits 7:0 become entry 2w+1. A write to plane 3 changes nothing.
- R2: Palette byte enable 2 gates entry 2w and byte enable 0 gates entry 2w+1. Enables 3 and 1, and data bits 31:24 and 15:8, have no effect on any entry.
- R3: A control write to word k loads register 2k from bits 23:16 under byte enable 2, and register 2k+1 from bits 7:0 under byte enable 0. Only the low byte of each register is kept.
- R4: Registers 0x08, 0x09 and 0x0A hold the background red, green and blue. Any valid pixel that no enabled layer covers outputs the background colour.
- R5: The text palette index is ((reg 0x1B << 8) & 0x7F00) + bank*16 + nibble, taken modulo 2^IDX_W.
- R6: Register 0x1F bit 0 enables the polygon layer and bit 2 enables the text layer. A polygon pixel counts only when `poly_valid_i` is high.
- R7: An enabled text pixel with a non-zero nibble outputs its palette colour over everything. A nibble of 0 is transparent. Otherwise an enabled, valid polygon pixel outputs `poly_rgb_i`.
- R8: `out_valid_o`, `out_sb_o` and `out_rgb_o` show the pixel presented one clock edge earlier.
- R9: After reset, `out_valid_o` is 0, `out_rgb_o` is 0, both layers are disabled and the background is black.
- R10: Writes to control registers other than 0x08, 0x09, 0x0A, 0x1B and 0x1F have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pal_we_i | input | 1 | Palette word write strobe |
| pal_addr_i | input | IDX_W+1 | Plane select and word address |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_addr_i | input | 4 | Control word address |
| wdata_i | input | 32 | Write data, shared by both targets |
| wbe_i | input | 4 | Byte enables, bit 3 = bits 31:24 |
| pix_valid_i | input | 1 | Pixel present this cycle |
| pix_sb_i | input | SB_W | Pixel sideband, delayed with the pixel |
| poly_valid_i | input | 1 | Polygon layer covers this pixel |
| poly_rgb_i | input | 24 | Polygon colour {r,g,b} |
| text_bank_i | input | 4 | Text colour bank from the tile attribute |
| text_nib_i | input | 4 | Text pixel nibble, 0 = transparent |
| out_valid_o | output | 1 | Output pixel valid |
| out_sb_o | output | SB_W | Delayed sideband |
| out_rgb_o | output | 24 | Mixed colour {r,g,b} |

## Verification
The assertions assume that the pixel inputs hold known values whenever `pix_valid_i` is high. They also sample the control state at the same edge as the pixel, so a control write in that cycle takes effect only for later pixels. A lookup that hits a palette entry written on the same edge would return the old entry. The stimulus therefore keeps palette and control writes in their own cycles, apart from pixel traffic. It drives all inputs one nanosecond after the rising edge, which keeps each lookup a plain registered read.

// File: rtl/pal_mixer_pkg.sv
package pal_mixer_pkg;
  localparam int unsigned CTL_AW = 4;
  localparam logic [4:0] REG_BG_R    = 5'h08;
  localparam logic [4:0] REG_BG_G    = 5'h09;
  localparam logic [4:0] REG_BG_B    = 5'h0A;
  localparam logic [4:0] REG_TXT_BASE = 5'h1B;
  localparam logic [4:0] REG_LAYER   = 5'h1F;
  localparam int unsigned LAYER_POLY_BIT = 0;
  localparam int unsigned LAYER_TEXT_BIT = 2;
  localparam int unsigned NUM_PLANES = 3;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;
endpackage

// File: rtl/pal_plane.sv
module pal_plane #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_hi_i,
  input  logic             we_lo_i,
  input  logic [IDX_W-2:0] waddr_i,
  input  logic [7:0]       wd_hi_i,
  input  logic [7:0]       wd_lo_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_hi_i) mem[{waddr_i, 1'b0}] <= wd_hi_i;
    if (we_lo_i) mem[{waddr_i, 1'b1}] <= wd_lo_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/mix_ctl.sv
module mix_ctl
  import pal_mixer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTL_AW-1:0] addr_i,
  input  logic              be_hi_i,
  input  logic              be_lo_i,
  input  logic [7:0]        wd_hi_i,
  input  logic [7:0]        wd_lo_i,
  output rgb_t              bg_o,
  output logic [6:0]        txt_base_o,
  output logic              poly_en_o,
  output logic              text_en_o
);
  logic [4:0] idx_hi, idx_lo;
  assign idx_hi = {addr_i, 1'b0};
  assign idx_lo = {addr_i, 1'b1};

  // even register in upper half, odd in lower half
  function automatic logic hit(input logic [4:0] r, input logic [4:0] ih, input logic [4:0] il,
                               input logic bh, input logic bl);
    return (bh && ih == r) || (bl && il == r);
  endfunction

  function automatic logic [7:0] pick(input logic [4:0] r, input logic [4:0] ih,
                                      input logic [7:0] dh, input logic [7:0] dl);
    return (ih == r) ? dh : dl;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bg_o       <= '0;
      txt_base_o <= '0;
      poly_en_o  <= 1'b0;
      text_en_o  <= 1'b0;
    end else if (we_i) begin
      if (hit(REG_BG_R, idx_hi, idx_lo, be_hi_i, be_lo_i))
        bg_o.r <= pick(REG_BG_R, idx_hi, wd_hi_i, wd_lo_i);
      if (hit(REG_BG_G, idx_hi, idx_lo, be_hi_i, be_lo_i))
        bg_o.g <= pick(REG_BG_G, idx_hi, wd_hi_i, wd_lo_i);
      if (hit(REG_BG_B, idx_hi, idx_lo, be_hi_i, be_lo_i))
        bg_o.b <= pick(REG_BG_B, idx_hi, wd_hi_i, wd_lo_i);
      if (hit(REG_TXT_BASE, idx_hi, idx_lo, be_hi_i, be_lo_i))
        txt_base_o <= pick(REG_TXT_BASE, idx_hi, wd_hi_i, wd_lo_i)[6:0];
      if (hit(REG_LAYER, idx_hi, idx_lo, be_hi_i, be_lo_i)) begin
        poly_en_o <= pick(REG_LAYER, idx_hi, wd_hi_i, wd_lo_i)[LAYER_POLY_BIT];
        text_en_o <= pick(REG_LAYER, idx_hi, wd_hi_i, wd_lo_i)[LAYER_TEXT_BIT];
      end
    end
  end

  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable({bg_o, txt_base_o, poly_en_o, text_en_o})); // R3
endmodule

// File: rtl/pal_mixer.sv
module pal_mixer
  import pal_mixer_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned SB_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pal_we_i,
  input  logic [IDX_W:0]    pal_addr_i,
  input  logic              ctl_we_i,
  input  logic [3:0]        ctl_addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wbe_i,
  input  logic              pix_valid_i,
  input  logic [SB_W-1:0]   pix_sb_i,
  input  logic              poly_valid_i,
  input  logic [23:0]       poly_rgb_i,
  input  logic [3:0]        text_bank_i,
  input  logic [3:0]        text_nib_i,
  output logic              out_valid_o,
  output logic [SB_W-1:0]   out_sb_o,
  output logic [23:0]       out_rgb_o
);
  localparam int unsigned FULL_IDX_W = 15;

  logic unused_hi;
  assign unused_hi = ^{wdata_i[31:24], wdata_i[15:8], wbe_i[3], wbe_i[1]};

  rgb_t       bg;
  logic [6:0] txt_base;
  logic       poly_en, text_en;

  mix_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctl_we_i),
    .addr_i     (ctl_addr_i),
    .be_hi_i    (wbe_i[2]),
    .be_lo_i    (wbe_i[0]),
    .wd_hi_i    (wdata_i[23:16]),
    .wd_lo_i    (wdata_i[7:0]),
    .bg_o       (bg),
    .txt_base_o (txt_base),
    .poly_en_o  (poly_en),
    .text_en_o  (text_en)
  );

  logic [FULL_IDX_W-1:0] idx_full;
  logic [IDX_W-1:0]      rd_idx;
  assign idx_full = {txt_base, 8'h00} + {7'd0, text_bank_i, text_nib_i};
  assign rd_idx   = idx_full[IDX_W-1:0];

  logic [1:0] plane_sel;
  assign plane_sel = pal_addr_i[IDX_W:IDX_W-1];

  logic [7:0] plane_q [NUM_PLANES];

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic sel;
    assign sel = pal_we_i && (plane_sel == 2'(p));
    pal_plane #(.IDX_W(IDX_W)) u_plane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_hi_i (sel && wbe_i[2]),
      .we_lo_i (sel && wbe_i[0]),
      .waddr_i (pal_addr_i[IDX_W-2:0]),
      .wd_hi_i (wdata_i[23:16]),
      .wd_lo_i (wdata_i[7:0]),
      .raddr_i (rd_idx),
      .rdata_o (plane_q[p])
    );
  end

  logic      text_on_q, poly_on_q;
  logic [23:0] poly_q;
  rgb_t      bg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sb_o    <= '0;
      text_on_q   <= 1'b0;
      poly_on_q   <= 1'b0;
      poly_q      <= '0;
      bg_q        <= '0;
    end else begin
      out_valid_o <= pix_valid_i;
      out_sb_o    <= pix_sb_i;
      text_on_q   <= text_en && (text_nib_i != 4'd0);
      poly_on_q   <= poly_en && poly_valid_i;
      poly_q      <= poly_rgb_i;
      bg_q        <= bg;
    end
  end

  always_comb begin
    if (text_on_q)      out_rgb_o = {plane_q[0], plane_q[1], plane_q[2]};
    else if (poly_on_q) out_rgb_o = poly_q;
    else                out_rgb_o = bg_q;
  end

  AST_VALID_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> out_valid_o == $past(pix_valid_i)); // R8
  AST_SB_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> out_sb_o == $past(pix_sb_i)); // R8
  AST_POLY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && poly_valid_i && poly_en && text_nib_i == 4'd0
    |=> out_rgb_o == $past(poly_rgb_i)); // R7
  AST_BG_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && !(poly_valid_i && poly_en) && !(text_en && text_nib_i != 4'd0)
    |=> out_rgb_o == $past(bg)); // R4
  AST_TEXT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && !text_en && poly_valid_i && poly_en
    |=> out_rgb_o == $past(poly_rgb_i)); // R6
endmodule

// File: tb/sim_pal_mixer.sv
`timescale 1ns/1ps
module sim_pal_mixer;
  localparam int IDX_W = 10;
  localparam int SB_W  = 2;
  localparam int DEPTH = 1 << IDX_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic              pal_we_i = 0, ctl_we_i = 0;
  logic [IDX_W:0]    pal_addr_i = '0;
  logic [3:0]        ctl_addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [3:0]        wbe_i = '0;
  logic              pix_valid_i = 0, poly_valid_i = 0;
  logic [SB_W-1:0]   pix_sb_i = '0;
  logic [23:0]       poly_rgb_i = '0;
  logic [3:0]        text_bank_i = '0, text_nib_i = '0;
  logic              out_valid_o;
  logic [SB_W-1:0]   out_sb_o;
  logic [23:0]       out_rgb_o;

  pal_mixer #(.IDX_W(IDX_W), .SB_W(SB_W)) u0 (.*);

  int checks = 0, fails = 0;
  logic [7:0] m_pal [3][DEPTH];
  logic [7:0] m_reg [32];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pal_wr(input int plane, input int word, input logic [31:0] d, input logic [3:0] be);
    pal_we_i = 1; pal_addr_i = {plane[1:0], word[IDX_W-2:0]}; wdata_i = d; wbe_i = be;
    @(posedge clk_i); #1;
    pal_we_i = 0;
    if (plane < 3) begin
      if (be[2]) m_pal[plane][2*word]   = d[23:16];
      if (be[0]) m_pal[plane][2*word+1] = d[7:0];
    end
  endtask

  task automatic ctl_wr(input int k, input logic [31:0] d, input logic [3:0] be);
    ctl_we_i = 1; ctl_addr_i = k[3:0]; wdata_i = d; wbe_i = be;
    @(posedge clk_i); #1;
    ctl_we_i = 0;
    if (be[2]) m_reg[2*k]   = d[23:16];
    if (be[0]) m_reg[2*k+1] = d[7:0];
  endtask

  function automatic logic [23:0] exp_rgb(input logic pv, input logic [23:0] prgb,
                                          input logic [3:0] bank, input logic [3:0] nib);
    int idx;
    idx = ((int'(m_reg[8'h1B]) << 8) & 'h7F00) + bank * 16 + nib;
    idx = idx % DEPTH;
    if (m_reg[8'h1F][2] && nib != 0) return {m_pal[0][idx], m_pal[1][idx], m_pal[2][idx]};
    if (m_reg[8'h1F][0] && pv) return prgb;
    return {m_reg[8'h08], m_reg[8'h09], m_reg[8'h0A]};
  endfunction

  task automatic pix(input string req, input logic pv, input logic [23:0] prgb,
                     input logic [3:0] bank, input logic [3:0] nib, input logic [SB_W-1:0] sb);
    logic [23:0] e;
    e = exp_rgb(pv, prgb, bank, nib);
    pix_valid_i = 1; poly_valid_i = pv; poly_rgb_i = prgb;
    text_bank_i = bank; text_nib_i = nib; pix_sb_i = sb;
    @(posedge clk_i); #1;
    pix_valid_i = 0;
    chk(req, {31'd0, out_valid_o}, 32'd1);
    chk("R8 sideband", {30'd0, out_sb_o}, {30'd0, sb});
    chk(req, {8'd0, out_rgb_o}, {8'd0, e});
  endtask

  initial begin
    #900000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd4242);
    for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 valid", {31'd0, out_valid_o}, 32'd0);
    chk("R9 rgb", {8'd0, out_rgb_o}, 32'd0);
    rst_ni = 1;
    @(posedge clk_i); #1;

    // R1/R2: fill planes, random byte enables (be3/be1 data is junk)
    for (int p = 0; p < 3; p++)
      for (int w = 0; w < DEPTH / 2; w++) pal_wr(p, w, $urandom, 4'hF);
    for (int i = 0; i < 200; i++) pal_wr($urandom_range(0, 3), $urandom_range(0, DEPTH/2-1), $urandom, 4'($urandom));

    // R9: layers off after reset, bg black
    pix("R9 layers off", 1, 24'hABCDEF, 4'h3, 4'h5, 2'd1);

    // R4: background
    ctl_wr(4, 32'hFF12_0034, 4'hF);
    ctl_wr(5, 32'h0056_0000, 4'h4);
    pix("R4 bg", 0, 24'h0, 4'h0, 4'h0, 2'd2);

    // R10: reserved registers
    ctl_wr(6, 32'hFFFF_FFFF, 4'hF);
    ctl_wr(14, 32'hFFFF_FFFF, 4'hF);
    ctl_wr(15, 32'hFFFF_0000, 4'hC);
    pix("R10 reserved", 1, 24'h111111, 4'h2, 4'h2, 2'd3);

    // R6: polygon enable only
    ctl_wr(15, 32'h0000_0001, 4'h1);
    pix("R6 poly on", 1, 24'h445566, 4'h1, 4'h7, 2'd0);
    pix("R6 poly invalid", 0, 24'h445566, 4'h1, 4'h7, 2'd0);

    // R7: text over polygon, nibble 0 transparent
    ctl_wr(15, 32'h0000_0005, 4'h1);
    pix("R7 text over poly", 1, 24'h778899, 4'hA, 4'h3, 2'd1);
    pix("R7 transparent nib", 1, 24'h778899, 4'hA, 4'h0, 2'd1);

    // R5: palette base with bits past bit 6 masked; wrap modulo depth
    ctl_wr(13, 32'h0000_00FF, 4'h1);
    pix("R5 base masked", 0, 24'h0, 4'hF, 4'hF, 2'd2);
    ctl_wr(13, 32'h0000_0002, 4'h1);
    pix("R5 base", 0, 24'h0, 4'h4, 4'h9, 2'd2);

    // R2: be1/be3 only leave entries unchanged
    pal_wr(0, 256 + 36, 32'hEE00_EE00, 4'hA);
    pix("R2 be3 be1", 0, 24'h0, 4'h4, 4'h9, 2'd3);
    // R1: plane 3 ignored
    pal_wr(3, 256 + 36, 32'h0099_0099, 4'hF);
    pix("R1 plane3", 0, 24'h0, 4'h4, 4'h8, 2'd3);
    pal_wr(1, 256 + 36, 32'h00C3_003C, 4'h5);
    pix("R1 even entry", 0, 24'h0, 4'h4, 4'h8, 2'd0);
    pix("R1 odd entry", 0, 24'h0, 4'h4, 4'h9, 2'd0);

    // R3: control low byte only, upper half = even reg
    ctl_wr(4, 32'h00AB_00CD, 4'h5);
    pix("R3 bg halves", 0, 24'h0, 4'h0, 4'h0, 2'd1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 9) == 0)
        ctl_wr($urandom_range(0, 15), $urandom, 4'($urandom));
      pix("R7 random", 1'($urandom), 24'($urandom), 4'($urandom), 4'($urandom), 2'($urandom));
    end

    // R8: valid drops with the pixel
    @(posedge clk_i); #1;
    chk("R8 valid low", {31'd0, out_valid_o}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule